// File: doc/BRIEF.md
# Multichannel Bitstream RC Converter Controller

This block is the digital half of a first-order bitstream analog-to-digital converter. Each channel has one external resistor-capacitor node. A logic-threshold input senses that node, and a feedback output charges or discharges it. The converter runs at a slow sample tick, one tick every `TICK_DIV` system clocks. On each tick the block reads every synchronized sense input and drives the matching feedback output to the complement of it. This keeps each capacitor hovering at the input switching threshold, near mid-supply.

The fraction of ticks on which a channel's feedback is driven high follows the analog input voltage. The block counts those ticks in a saturating 8-bit accumulator per channel, over a window of 256 ticks. One window counter serves all channels. At the end of every window the block copies all counts into result registers together, clears the accumulators and pulses `result_valid_o` for one clock.

The results are published without back-pressure. There is no ready input. A consumer has a full window to capture a result, because each result holds its value until the next window ends. A constant input at or beyond the high rail reads 255, not 0. A floating input reads about 0x7F to 0x80.

Top module: `rcadc_ctrl`

## Requirements
- R1: An internal sample tick occurs once every `TICK_DIV` clocks (default 163). The first tick comes `TICK_DIV` clocks after reset is released, so consecutive result updates are exactly 256 * `TICK_DIV` clocks apart.
- R2: Each sense input passes through a two-flop synchronizer. On every tick, each feedback output is loaded with the complement of that channel's synchronized sense value, and it holds that value between ticks.
- R3: On a tick where a channel's new feedback value is high (sense low), that channel's accumulator goes up by one. On any other tick it is unchanged.
- R4: The accumulator saturates at 255 and never wraps. A sense input held low for a whole window (256 high feedback decisions) reads 255, and 255 low samples also read 255.
- R5: The window is 256 ticks long and is counted by one counter shared by all channels. On the 256th tick, every channel's count, including that tick's decision, is copied into its 8-bit result field. All fields update in the same clock.
- R6: In that same tick every accumulator is cleared, so each window counts only its own 256 decisions.
- R7: `result_valid_o` is high for exactly one clock, in the first cycle that shows the new results. Results stay constant at all other times.
- R8: Synchronous reset (`rst` high) clears the tick divider, the window counter, the accumulators and the results, and drives every feedback output and `result_valid_o` low.
- R9: A sense input held high for a whole window reads 0. A sense input that alternates on every tick reads 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_i | input | NCH | Threshold inputs from the RC nodes, asynchronous |
| feedback_o | output | NCH | Feedback drive to the RC nodes, one bit per channel |
| result_o | output | NCH*8 | Per-channel results; channel c occupies bits [8c+7:8c] |
| result_valid_o | output | 1 | One-clock pulse when new results are published |

## Verification
A faulty tick divider or window counter shows up as `result_valid_o` arriving at the wrong clock. This is visible at the first window, 256 ticks after reset. A feedback register that does not invert or hold shows at `feedback_o` on the very next tick. An accumulator that wraps, skips a clear or is updated on the wrong tick only becomes visible when the window ends, as a wrong result field. So the bench drives an exactly known count of low samples into each window and compares every field at each pulse. This includes the saturating counts 255 and 256 and the all-high count 0.

// File: rtl/rcadc_pkg.sv
package rcadc_pkg;
  localparam int unsigned DEF_CHANNELS = 2;
  localparam int unsigned DEF_TICK_DIV = 163;
  localparam int unsigned WIN_BITS     = 8;
  localparam int unsigned RES_W        = WIN_BITS;

  typedef logic [RES_W-1:0] res_t;

  function automatic res_t sat_inc(input res_t v, input logic en);
    if (en && (v != {RES_W{1'b1}})) return v + res_t'(1);
    return v;
  endfunction
endpackage

// File: rtl/rcadc_tick.sv
module rcadc_tick #(
  parameter int unsigned TICK_DIV = 163
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + CW'(1);
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R1
endmodule

// File: rtl/rcadc_sync.sv
module rcadc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rcadc_window.sv
module rcadc_window #(
  parameter int unsigned WBITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic win_end_o,
  output logic valid_o
);
  logic [WBITS-1:0] wcnt_q;
  logic             valid_q;

  assign win_end_o = tick_i && (wcnt_q == {WBITS{1'b1}});
  assign valid_o   = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= win_end_o;
      if (tick_i) wcnt_q <= wcnt_q + WBITS'(1);
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q); // R7
  AST_WIN_RESTART: assert property (@(posedge clk) disable iff (rst)
    win_end_o |=> (wcnt_q == '0)); // R5
endmodule

// File: rtl/rcadc_chan.sv
module rcadc_chan
  import rcadc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic win_end_i,
  input  logic sense_sync_i,
  output logic fb_o,
  output res_t result_o
);
  res_t acc_q, acc_nxt, res_q;
  logic fb_q, fb_dec;

  assign fb_dec  = ~sense_sync_i;
  assign acc_nxt = sat_inc(acc_q, fb_dec);

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_q  <= 1'b0;
      acc_q <= '0;
      res_q <= '0;
    end else if (tick_i) begin
      fb_q <= fb_dec;
      if (win_end_i) begin
        res_q <= acc_nxt;
        acc_q <= '0;
      end else begin
        acc_q <= acc_nxt;
      end
    end
  end

  assign fb_o     = fb_q;
  assign result_o = res_q;

  AST_FB_INVERTS: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> (fb_q == !$past(sense_sync_i))); // R2
  AST_FB_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(fb_q)); // R2
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !win_end_i) |=> ((acc_q - $past(acc_q)) <= res_t'(1))); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !win_end_i && (acc_q == {RES_W{1'b1}})) |=> (acc_q == {RES_W{1'b1}})); // R4
  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    win_end_i |=> (acc_q == '0)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !win_end_i |=> $stable(res_q)); // R7
endmodule

// File: rtl/rcadc_ctrl.sv
module rcadc_ctrl
  import rcadc_pkg::*;
#(
  parameter int unsigned NCH      = DEF_CHANNELS,
  parameter int unsigned TICK_DIV = DEF_TICK_DIV
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       sense_i,
  output logic [NCH-1:0]       feedback_o,
  output logic [NCH*RES_W-1:0] result_o,
  output logic                 result_valid_o
);
  logic tick, win_end;

  rcadc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  rcadc_window #(.WBITS(WIN_BITS)) u_window (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .win_end_o (win_end),
    .valid_o   (result_valid_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sense_s;

    rcadc_sync #(.STAGES(2)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (sense_i[c]),
      .q_o (sense_s)
    );

    rcadc_chan u_chan (
      .clk          (clk),
      .rst          (rst),
      .tick_i       (tick),
      .win_end_i    (win_end),
      .sense_sync_i (sense_s),
      .fb_o         (feedback_o[c]),
      .result_o     (result_o[c*RES_W +: RES_W])
    );
  end

  AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    win_end |=> result_valid_o); // R5
endmodule

// File: tb/test_rcadc_ctrl.sv
module test_rcadc_ctrl;
  localparam int NCH = 4;
  localparam int DIV = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCH-1:0]   sense = '0;
  logic [NCH-1:0]   fb;
  logic [NCH*8-1:0] res;
  logic             vld;

  int n_run  = 0;
  int n_fail = 0;
  logic [NCH-1:0] prev_sense = '0;
  int exp_prev [NCH];

  // stimulus table: {alternate, low-count per channel}
  localparam int NV = 6;
  localparam int VEC [NV][NCH+1] = '{
    '{0, 0,   256, 128, 1},
    '{0, 255, 254, 256, 127},
    '{0, 2,   0,   200, 255},
    '{1, 0,   0,   0,   0},
    '{0, 64,  192, 3,   253},
    '{0, 256, 256, 256, 256}
  };

  always #4 clk = ~clk;

  rcadc_ctrl #(.NCH(NCH), .TICK_DIV(DIV)) i_rcadc_ctrl (
    .clk            (clk),
    .rst            (rst),
    .sense_i        (sense),
    .feedback_o     (fb),
    .result_o       (res),
    .result_valid_o (vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Assumes the current time is the negedge where vld is high.
  // alt=1 alternates every tick; otherwise sense low for the first nlow slots.
  task automatic run_window(input bit alt, input int nlow [NCH]);
    int fb_bad = 0;
    int vld_bad = 0;
    int hold_bad = 0;
    for (int k = 0; k < 256; k++) begin
      if (fb !== ~prev_sense) fb_bad++;
      if (k > 0 && vld !== 1'b0) vld_bad++;
      if (k == 128) begin
        for (int c = 0; c < NCH; c++)
          if (int'(res[c*8 +: 8]) != exp_prev[c]) hold_bad++;
      end
      for (int c = 0; c < NCH; c++)
        sense[c] = alt ? k[0] : ((k < nlow[c]) ? 1'b0 : 1'b1);
      prev_sense = sense;
      repeat (DIV) @(negedge clk);
    end
    check(fb_bad == 0, "R2 feedback is complement of sampled sense", fb_bad, 0);
    check(vld_bad == 0, "R7 valid low inside window", vld_bad, 0);
    check(hold_bad == 0, "R7 results hold mid-window", hold_bad, 0);
    check(vld === 1'b1, "R5 R1 valid after 256 ticks", int'(vld), 1);
    for (int c = 0; c < NCH; c++) begin
      int e;
      e = alt ? 128 : ((nlow[c] > 255) ? 255 : nlow[c]);
      check(int'(res[c*8 +: 8]) == e, "R3 R4 R6 R9 channel result",
            int'(res[c*8 +: 8]), e);
      exp_prev[c] = e;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    int nl [NCH];
    repeat (3) @(negedge clk);
    check(fb == '0 && res == '0 && vld == 1'b0, "R8 reset state", int'(res), 0);
    rst = 1'b0;
    cyc = 0;
    while (vld !== 1'b1) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 256 * DIV, "R1 first window length", cyc, 256 * DIV);
    for (int c = 0; c < NCH; c++) begin
      check(int'(res[c*8 +: 8]) == 255, "R4 full scale reads 255",
            int'(res[c*8 +: 8]), 255);
      exp_prev[c] = 255;
    end

    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < NCH; c++) nl[c] = VEC[v][c+1];
      run_window(VEC[v][0] != 0, nl);
    end

    // Directed: reset mid-window
    repeat (40) @(negedge clk);
    rst = 1'b1;
    sense = '1;
    prev_sense = sense;
    repeat (2) @(negedge clk);
    check(res == '0, "R8 reset clears results", int'(res[7:0]), 0);
    check(fb == '0, "R8 reset drives feedback low", int'(fb), 0);
    check(vld == 1'b0, "R8 reset clears valid", int'(vld), 0);
    rst = 1'b0;
    cyc = 0;
    while (vld !== 1'b1) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 256 * DIV, "R1 window restarts after reset", cyc, 256 * DIV);
    for (int c = 0; c < NCH; c++) begin
      check(int'(res[c*8 +: 8]) == 0, "R9 constant high reads 0",
            int'(res[c*8 +: 8]), 0);
      exp_prev[c] = 0;
    end
    for (int c = 0; c < NCH; c++) nl[c] = 256;
    run_window(1'b0, nl);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule